// File: doc/BRIEF.md
# Event-Driven I2C Byte Master

This block is an I2C master that a host steers one bus event at a time through a small register file. The host asks for a START, a STOP, a byte transmit or a byte receive. The engine then carries out that event on open-drain SCL and SDA lines. It posts an 8-bit code that describes how the event ended, and for every event except STOP it sets a completion flag. The next queued byte transfer starts when the host clears that flag. In this way the host walks through a transfer as a series of checked steps: START, address, data bytes and STOP. A repeated START is requested in the same way as a first START while the bus is still held.

The bit timing comes from a fixed quarter-period counter. Each bit takes four phases of `QTR_CYCLES` clocks. The baud register is kept so that the host can store and read back a setting, and a soft-reset write puts the whole engine and its configuration back to the power-up state. The outputs `scl_oe` and `sda_oe` mean "pull the line low". External pull-ups give the high level, and the sampled SDA level comes back on `sda_i`.

Top module: `twm_master`

## Requirements
- R1: After reset, status reads 0xF8, control reads 0x00, baud reads 0x44, both own-address registers read 0x00, `irq` is low and both lines are released.
- R2: Writing control with the enable bit (bit 6) and the START bit (bit 5) set, and the flag bit (bit 3) at 0, generates a START. When it completes, the flag is set and status reads 0x08. If the bus is already held, status reads 0x10 instead, and SCL stays held low after either code.
- R3: After a START, clearing the flag with enable set sends the data register MSB first as an address. Bit 0 of that byte gives the direction. Status then reads 0x18 (write, ACK), 0x20 (write, NAK), 0x40 (read, ACK) or 0x48 (read, NAK). SDA changes while SCL is released only inside START and STOP.
- R4: After a write-direction address, each flag clear sends the data register as a data byte. Status reads 0x28 if the receiver returned ACK and 0x30 if it returned NAK.
- R5: After a read-direction address with ACK, each flag clear receives a byte into the data register. The ACK bit (bit 2) in that control write selects whether the master returns ACK (status 0x50) or NAK (status 0x58).
- R6: A control write with the STOP bit (bit 4) and enable set generates a STOP. It does not set the flag. Status returns to 0xF8 and both lines are released.
- R7: Status takes a new code in the same cycle that the flag rises. While an event is in progress, status keeps the previous code.
- R8: `irq` is high exactly when the flag is set and the interrupt-enable bit (bit 7) is set. Writing 1 to the flag bit leaves the flag unchanged and launches nothing.
- R9: With the enable bit at 0, a control write launches nothing: the lines stay released, `irq` stays low and status is unchanged.
- R10: Any write to offset 6 aborts a held bus and releases both lines. It clears the control bits and the flag, sets status to 0xF8, restores baud to 0x44 and clears both own-address registers.
- R11: The register offsets are control 0, status 1 (read-only), data 2, baud 3, own address 4, extended own address 5 and soft reset 6 (write-only). The value read appears on `reg_rdata` one cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| irq | output | 1 | Interrupt: flag and interrupt enable |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The bench builds the block with `QTR_CYCLES = 4`, which makes one bit 16 clocks long. At that length whole transactions fit easily within the run, including address and data phases, repeated STARTs, multi-byte reads with ACK and then NAK, and STOPs. A behavioural open-drain target on the bench side gives the NAK paths. It refuses unknown addresses and rejects the data byte 0xFF, so every ACK and NAK status code can be reached. The other parameters keep their defaults, so the register map and the 0x44 baud reset value are the ones the requirements state.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int BYTE_W = 8;

  // bus event result codes
  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NAK  = 8'h20;
  localparam logic [7:0] ST_DW_ACK  = 8'h28;
  localparam logic [7:0] ST_DW_NAK  = 8'h30;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NAK  = 8'h48;
  localparam logic [7:0] ST_RX_ACK  = 8'h50;
  localparam logic [7:0] ST_RX_NAK  = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  // control bit positions
  localparam int CB_ACK   = 2;
  localparam int CB_FLAG  = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_START = 5;
  localparam int CB_EN    = 6;
  localparam int CB_IEN   = 7;

  // register offsets
  localparam int OFF_CTRL = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_DATA = 2;
  localparam int OFF_BAUD = 3;
  localparam int OFF_OWN  = 4;
  localparam int OFF_XOWN = 5;
  localparam int OFF_SRST = 6;

  typedef enum logic [1:0] {PC_START, PC_STOP, PC_WR, PC_RD} phy_cmd_e;
  typedef enum logic [1:0] {OP_START, OP_STOP, OP_SEND, OP_RECV} op_e;
endpackage

// File: rtl/twm_bitphy.sv
module twm_bitphy
  import twm_pkg::*;
#(
  parameter int QTR_CYCLES = 125
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cmd_valid,
  input  phy_cmd_e cmd,
  input  logic     wbit,
  output logic     done,
  output logic     rbit,
  output logic     held,
  output logic     scl_oe,
  output logic     sda_oe,
  input  logic     sda_i
);
  localparam int CW = (QTR_CYCLES < 2) ? 1 : $clog2(QTR_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(QTR_CYCLES - 1);

  logic          busy;
  phy_cmd_e      cmd_q;
  logic          wbit_q;
  logic [1:0]    phase;
  logic [CW-1:0] cnt;
  logic          scl_n, sda_n;

  // line levels per command and phase (1 = pull low)
  always_comb begin
    scl_n = 1'b1;
    sda_n = 1'b0;
    unique case (cmd_q)
      PC_START: begin
        scl_n = (phase == 2'd0) ? held : (phase == 2'd3);
        sda_n = phase[1];
      end
      PC_STOP: begin
        scl_n = (phase == 2'd0);
        sda_n = !phase[1];
      end
      PC_WR: begin
        scl_n = (phase == 2'd0) || (phase == 2'd3);
        sda_n = !wbit_q;
      end
      PC_RD: begin
        scl_n = (phase == 2'd0) || (phase == 2'd3);
        sda_n = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cmd_q  <= PC_START;
      wbit_q <= 1'b0;
      phase  <= 2'd0;
      cnt    <= '0;
      done   <= 1'b0;
      rbit   <= 1'b0;
      held   <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy   <= 1'b1;
          cmd_q  <= cmd;
          wbit_q <= wbit;
          phase  <= 2'd0;
          cnt    <= '0;
        end
      end else begin
        scl_oe <= scl_n;
        sda_oe <= sda_n;
        if (cnt == CNT_LAST) begin
          cnt   <= '0;
          phase <= phase + 2'd1;
          if (phase == 2'd1) rbit <= sda_i;
          if (phase == 2'd3) begin
            busy <= 1'b0;
            done <= 1'b1;
            held <= (cmd_q != PC_STOP);
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_CMD_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !busy); // R3
  AST_SDA_EDGE_RULE: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (cmd_q == PC_START || cmd_q == PC_STOP)); // R3
endmodule

// File: rtl/twm_byteseq.sv
module twm_byteseq
  import twm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  op_e               op,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              is_addr,
  input  logic              ack_en,
  output logic              busy,
  output logic              st_upd,
  output logic              ev_done,
  output logic [7:0]        st_code,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              phy_valid,
  output phy_cmd_e          phy_cmd,
  output logic              phy_wbit,
  input  logic              phy_done,
  input  logic              phy_rbit,
  input  logic              phy_held
);
  localparam logic [3:0] LAST_IDX = 4'(BYTE_W);

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} sq_e;

  sq_e               state;
  op_e               op_q;
  logic [BYTE_W-1:0] sh;
  logic [3:0]        idx;
  logic              addr_q, rdir_q, ack_q, rep_q;
  logic [7:0]        code_n;

  assign busy      = (state != SQ_IDLE);
  assign phy_valid = (state == SQ_ISSUE);

  always_comb begin
    phy_cmd  = PC_START;
    phy_wbit = 1'b1;
    unique case (op_q)
      OP_START: phy_cmd = PC_START;
      OP_STOP:  phy_cmd = PC_STOP;
      OP_SEND: begin
        phy_cmd  = (idx < LAST_IDX) ? PC_WR : PC_RD;
        phy_wbit = sh[BYTE_W-1];
      end
      OP_RECV: begin
        phy_cmd  = (idx < LAST_IDX) ? PC_RD : PC_WR;
        phy_wbit = !ack_q;
      end
      default: ;
    endcase
  end

  // completion code from the event kind and the sampled ACK
  always_comb begin
    code_n = ST_IDLE;
    unique case (op_q)
      OP_START: code_n = rep_q ? ST_RSTART : ST_START;
      OP_STOP:  code_n = ST_IDLE;
      OP_SEND: begin
        if (addr_q && rdir_q) code_n = !phy_rbit ? ST_AR_ACK : ST_AR_NAK;
        else if (addr_q)      code_n = !phy_rbit ? ST_AW_ACK : ST_AW_NAK;
        else                  code_n = !phy_rbit ? ST_DW_ACK : ST_DW_NAK;
      end
      OP_RECV:  code_n = ack_q ? ST_RX_ACK : ST_RX_NAK;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      op_q    <= OP_START;
      sh      <= '0;
      idx     <= '0;
      addr_q  <= 1'b0;
      rdir_q  <= 1'b0;
      ack_q   <= 1'b0;
      rep_q   <= 1'b0;
      st_upd  <= 1'b0;
      ev_done <= 1'b0;
      st_code <= ST_IDLE;
      rx_byte <= '0;
    end else begin
      st_upd  <= 1'b0;
      ev_done <= 1'b0;
      unique case (state)
        SQ_IDLE: if (op_valid) begin
          state  <= SQ_ISSUE;
          op_q   <= op;
          sh     <= tx_byte;
          idx    <= '0;
          addr_q <= is_addr;
          rdir_q <= tx_byte[0];
          ack_q  <= ack_en;
          rep_q  <= phy_held;
        end
        SQ_ISSUE: state <= SQ_WAIT;
        SQ_WAIT: if (phy_done) begin
          if ((op_q == OP_SEND || op_q == OP_RECV) && idx < LAST_IDX) begin
            if (op_q == OP_SEND) sh <= {sh[BYTE_W-2:0], 1'b0};
            else                 sh <= {sh[BYTE_W-2:0], phy_rbit};
            idx   <= idx + 4'd1;
            state <= SQ_ISSUE;
          end else begin
            state   <= SQ_IDLE;
            st_upd  <= 1'b1;
            ev_done <= (op_q != OP_STOP);
            st_code <= code_n;
            if (op_q == OP_RECV) rx_byte <= sh;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_BIT_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST_IDX); // R3
  AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (state == SQ_IDLE)); // R7
endmodule

// File: rtl/twm_master.sv
module twm_master
  import twm_pkg::*;
#(
  parameter int         QTR_CYCLES = 125,
  parameter int         AW         = 3,
  parameter logic [7:0] BAUD_RST   = 8'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_i
);
  logic              en_q, ien_q, ack_q, flag_q;
  logic              en_d, ien_d, ack_d, flag_d;
  logic [BYTE_W-1:0] data_q, baud_q, own_q, xown_q;
  logic [7:0]        status_q;
  logic              rd_mode_q, srst_q, sub_rst;

  logic ctrl_wr, soft_hit, flag_after, can_go;
  logic go_start, go_stop, go_byte, is_addr;
  op_e  op_sel;

  logic              seq_busy, seq_upd, seq_done;
  logic [7:0]        seq_code;
  logic [BYTE_W-1:0] seq_rx;
  logic              phy_valid, phy_wbit, phy_done, phy_rbit, phy_held;
  phy_cmd_e          phy_cmd;

  assign sub_rst    = rst | srst_q;
  assign ctrl_wr    = reg_wr && (reg_addr == AW'(OFF_CTRL));
  assign soft_hit   = reg_wr && (reg_addr == AW'(OFF_SRST));
  assign flag_after = flag_q & reg_wdata[CB_FLAG];
  assign can_go     = ctrl_wr && reg_wdata[CB_EN] && !flag_after && !seq_busy && !seq_upd;
  assign go_start   = can_go && reg_wdata[CB_START];
  assign go_stop    = can_go && !reg_wdata[CB_START] && reg_wdata[CB_STOP];
  assign go_byte    = can_go && !reg_wdata[CB_START] && !reg_wdata[CB_STOP] && flag_q;
  assign is_addr    = (status_q == ST_START) || (status_q == ST_RSTART);

  always_comb begin
    if (go_start)                      op_sel = OP_START;
    else if (go_stop)                  op_sel = OP_STOP;
    else if (rd_mode_q && !is_addr)    op_sel = OP_RECV;
    else                               op_sel = OP_SEND;
  end

  // next values of the control bits
  always_comb begin
    en_d   = en_q;
    ien_d  = ien_q;
    ack_d  = ack_q;
    flag_d = flag_q;
    if (ctrl_wr) begin
      en_d   = reg_wdata[CB_EN];
      ien_d  = reg_wdata[CB_IEN];
      ack_d  = reg_wdata[CB_ACK];
      flag_d = flag_after;
    end
    if (seq_upd && seq_done && !srst_q) flag_d = 1'b1;
    if (soft_hit) begin
      en_d   = 1'b0;
      ien_d  = 1'b0;
      ack_d  = 1'b0;
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      ien_q  <= 1'b0;
      ack_q  <= 1'b0;
      flag_q <= 1'b0;
      irq    <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      ien_q  <= ien_d;
      ack_q  <= ack_d;
      flag_q <= flag_d;
      irq    <= flag_d & ien_d;
      srst_q <= soft_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_hit) begin
      data_q    <= '0;
      baud_q    <= BAUD_RST;
      own_q     <= '0;
      xown_q    <= '0;
      status_q  <= ST_IDLE;
      rd_mode_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == AW'(OFF_DATA)) data_q <= reg_wdata;
      if (reg_wr && reg_addr == AW'(OFF_BAUD)) baud_q <= reg_wdata;
      if (reg_wr && reg_addr == AW'(OFF_OWN))  own_q  <= reg_wdata;
      if (reg_wr && reg_addr == AW'(OFF_XOWN)) xown_q <= reg_wdata;
      if (seq_upd && !srst_q) begin
        status_q  <= seq_code;
        rd_mode_q <= (seq_code == ST_AR_ACK) || (seq_code == ST_RX_ACK) ||
                     (seq_code == ST_RX_NAK);
        if (seq_code == ST_RX_ACK || seq_code == ST_RX_NAK) data_q <= seq_rx;
      end
      if (go_start || go_stop) rd_mode_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (int'(reg_addr))
        OFF_CTRL: reg_rdata <= {ien_q, en_q, 2'b00, flag_q, ack_q, 2'b00};
        OFF_STAT: reg_rdata <= status_q;
        OFF_DATA: reg_rdata <= data_q;
        OFF_BAUD: reg_rdata <= baud_q;
        OFF_OWN:  reg_rdata <= own_q;
        OFF_XOWN: reg_rdata <= xown_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  twm_byteseq i_seq (
    .clk       (clk),
    .rst       (sub_rst),
    .op_valid  (go_start | go_stop | go_byte),
    .op        (op_sel),
    .tx_byte   (data_q),
    .is_addr   (is_addr),
    .ack_en    (reg_wdata[CB_ACK]),
    .busy      (seq_busy),
    .st_upd    (seq_upd),
    .ev_done   (seq_done),
    .st_code   (seq_code),
    .rx_byte   (seq_rx),
    .phy_valid (phy_valid),
    .phy_cmd   (phy_cmd),
    .phy_wbit  (phy_wbit),
    .phy_done  (phy_done),
    .phy_rbit  (phy_rbit),
    .phy_held  (phy_held)
  );

  twm_bitphy #(.QTR_CYCLES(QTR_CYCLES)) i_phy (
    .clk       (clk),
    .rst       (sub_rst),
    .cmd_valid (phy_valid),
    .cmd       (phy_cmd),
    .wbit      (phy_wbit),
    .done      (phy_done),
    .rbit      (phy_rbit),
    .held      (phy_held),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .sda_i     (sda_i)
  );

  AST_IRQ_IS_FLAG_AND_IEN: assert property (@(posedge clk) disable iff (rst)
    irq == (flag_q & ien_q)); // R8
  AST_FLAG_RISES_ON_EVENT: assert property (@(posedge clk) disable iff (sub_rst)
    $rose(flag_q) |-> $past(seq_done)); // R7
  AST_STATUS_HELD_BUSY: assert property (@(posedge clk) disable iff (sub_rst)
    (seq_busy && $past(seq_busy)) |-> $stable(status_q)); // R7
  AST_STOP_NO_FLAG: assert property (@(posedge clk) disable iff (sub_rst)
    (seq_upd && seq_code == ST_IDLE) |=> !flag_q); // R6
endmodule

// File: tb/test_twm_master.sv
`timescale 1ns/1ps
module test_twm_master;
  localparam logic [7:0] C_EN = 8'h40, C_IE = 8'h80, C_ST = 8'h20,
                         C_SP = 8'h10, C_AK = 8'h04;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       s_drive = 1'b0;

  wire scl_bus = !scl_oe;
  wire sda_bus = !(sda_oe | s_drive);

  always #10 clk = ~clk;

  twm_master #(.QTR_CYCLES(4)) i_twm_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_bus)
  );

  int  checks = 0, fails = 0;
  bit  finished = 0;

  // behavioural target at address 0x50
  logic       s_act = 0, s_fresh = 0, s_send = 0, s_first = 0, s_match = 0, m_ack = 0;
  int         s_bc = 0;
  logic [7:0] s_sh = 0, s_tx = 0, s_last_wr = 0;

  always @(negedge sda_bus) if (scl_bus === 1'b1) begin
    s_act = 1; s_fresh = 1; s_bc = 0; s_send = 0; s_first = 1; s_drive = 0;
  end
  always @(posedge sda_bus) if (scl_bus === 1'b1) begin
    s_act = 0; s_send = 0; s_drive = 0;
  end
  always @(posedge scl_bus) if (s_act) begin
    if (s_bc < 8) begin
      if (!s_send) s_sh = {s_sh[6:0], sda_bus};
    end else if (s_send) m_ack = !sda_bus;
  end
  always @(negedge scl_bus) if (s_act) begin
    if (s_fresh) s_fresh = 0;
    else begin
      s_bc = s_bc + 1;
      if (s_bc == 8) begin
        if (s_send) s_drive = 0;
        else if (s_first) begin s_match = (s_sh[7:1] == 7'h50); s_drive = s_match; end
        else begin s_drive = (s_sh != 8'hFF); s_last_wr = s_sh; end
      end else if (s_bc == 9) begin
        s_bc = 0;
        if (s_first) begin
          s_first = 0;
          if (!s_match) begin s_act = 0; s_drive = 0; end
          else if (s_sh[0]) begin s_send = 1; s_tx = 8'hA5; s_drive = !s_tx[7]; end
          else s_drive = 0;
        end else if (s_send) begin
          if (m_ack) begin s_tx = s_tx + 8'd1; s_drive = !s_tx[7]; end
          else begin s_send = 0; s_act = 0; s_drive = 0; end
        end else s_drive = 0;
      end else if (s_send) s_drive = !s_tx[7 - s_bc];
    end
  end

  // scoreboard for register reads
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend = 1'b0;

  always @(posedge clk) rd_pend <= reg_rd && !rst;
  always @(negedge clk) if (rd_pend) begin
    logic [7:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s: read %02h expected %02h", t, reg_rdata, e);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    check(irq === 1'b1, {tag, " flag"}, {7'd0, irq}, 8'h01);
  endtask

  task automatic bstart(input logic [7:0] e, input string tag);
    wr(3'd0, C_IE | C_EN | C_ST);
    wait_irq(tag);
    rd_exp(3'd1, e, tag);
  endtask

  task automatic bsend(input logic [7:0] b, input logic [7:0] e, input string tag);
    wr(3'd2, b);
    wr(3'd0, C_IE | C_EN);
    wait_irq(tag);
    rd_exp(3'd1, e, tag);
  endtask

  task automatic brecv(input bit ack, input logic [7:0] e, input logic [7:0] d, input string tag);
    wr(3'd0, C_IE | C_EN | (ack ? C_AK : 8'h00));
    wait_irq(tag);
    rd_exp(3'd1, e, tag);
    rd_exp(3'd2, d, tag);
  endtask

  task automatic bstop(input string tag);
    wr(3'd0, C_IE | C_EN | C_SP);
    repeat (40) @(negedge clk);
    rd_exp(3'd1, 8'hF8, tag);
    check(irq == 1'b0, {tag, " no flag"}, {7'd0, irq}, 8'h00);
    check(scl_bus && sda_bus, {tag, " lines free"}, {6'd0, scl_bus, sda_bus}, 8'h03);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got 00 expected 01");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_exp(3'd1, 8'hF8, "R1 status");
    rd_exp(3'd0, 8'h00, "R1 ctrl");
    rd_exp(3'd3, 8'h44, "R1 baud");
    rd_exp(3'd4, 8'h00, "R1 own");
    check(irq == 1'b0, "R1 irq", {7'd0, irq}, 8'h00);
    check(scl_bus && sda_bus, "R1 lines", {6'd0, scl_bus, sda_bus}, 8'h03);

    // R11 register map
    wr(3'd2, 8'h5A); rd_exp(3'd2, 8'h5A, "R11 data");
    wr(3'd5, 8'h6B); rd_exp(3'd5, 8'h6B, "R11 xown");
    rd_exp(3'd4, 8'h00, "R11 own untouched");

    // R9 disabled controller ignores START
    wr(3'd0, C_ST | C_IE);
    repeat (40) @(negedge clk);
    check(scl_bus && sda_bus, "R9 lines", {6'd0, scl_bus, sda_bus}, 8'h03);
    check(irq == 1'b0, "R9 irq", {7'd0, irq}, 8'h00);
    rd_exp(3'd1, 8'hF8, "R9 status");

    // write transfer: R2 R3 R4 R7
    bstart(8'h08, "R2 start");
    check(scl_bus == 1'b0, "R2 scl held", {7'd0, scl_bus}, 8'h00);
    bsend(8'hA0, 8'h18, "R3 addr write ack");
    wr(3'd2, 8'h3C);
    wr(3'd0, C_IE | C_EN);
    rd_exp(3'd1, 8'h18, "R7 status held while busy");
    wait_irq("R4");
    rd_exp(3'd1, 8'h28, "R4 data ack");
    check(s_last_wr == 8'h3C, "R3 msb first byte", s_last_wr, 8'h3C);
    bsend(8'hFF, 8'h30, "R4 data nak");
    bstop("R6 stop");

    // read transfer with repeated start: R2 R3 R5
    bstart(8'h08, "R2 start");
    bsend(8'hA0, 8'h18, "R3 addr write ack");
    bstart(8'h10, "R2 repeated start");
    bsend(8'hA1, 8'h40, "R3 addr read ack");
    brecv(1'b1, 8'h50, 8'hA5, "R5 rx ack");
    brecv(1'b0, 8'h58, 8'hA6, "R5 rx nak");
    bstop("R6 stop");

    // absent target, read direction
    bstart(8'h08, "R2 start");
    bsend(8'h45, 8'h48, "R3 addr read nak");
    bstop("R6 stop");

    // R8 interrupt gating, then absent target write direction
    wr(3'd0, C_EN | C_ST);
    repeat (40) @(negedge clk);
    check(irq == 1'b0, "R8 irq masked", {7'd0, irq}, 8'h00);
    rd_exp(3'd0, 8'h48, "R8 flag set");
    wr(3'd0, C_IE | C_EN | 8'h08);
    check(irq == 1'b1, "R8 irq enabled", {7'd0, irq}, 8'h01);
    repeat (40) @(negedge clk);
    rd_exp(3'd1, 8'h08, "R8 write 1 no launch");
    bsend(8'h44, 8'h20, "R3 addr write nak");
    bstop("R6 stop");

    // R10 soft reset during held bus
    wr(3'd3, 8'h12);
    wr(3'd4, 8'h33);
    rd_exp(3'd3, 8'h12, "R11 baud");
    bstart(8'h08, "R2 start");
    wr(3'd6, 8'h00);
    repeat (4) @(negedge clk);
    check(scl_bus && sda_bus, "R10 lines", {6'd0, scl_bus, sda_bus}, 8'h03);
    check(irq == 1'b0, "R10 irq", {7'd0, irq}, 8'h00);
    rd_exp(3'd1, 8'hF8, "R10 status");
    rd_exp(3'd3, 8'h44, "R10 baud");
    rd_exp(3'd4, 8'h00, "R10 own");
    rd_exp(3'd5, 8'h00, "R10 xown");
    rd_exp(3'd0, 8'h00, "R10 ctrl");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule